// File: doc/BRIEF.md
# Timed-Access Write Guard

This block protects selected bits of a handful of special-function registers in a small microcontroller core from stray writes. It watches the core's internal register-write bus (address, data, write strobe) and a cycle-enable that marks the cycles in which the bus is valid. For each guarded register it produces a byte-wide write-enable mask, which the register uses in place of a plain write strobe.

Bits that are not protected can be written at any time. A protected bit can only be written after an unlock sequence: two back-to-back writes to a dedicated key register, first AAh and then 55h. The sequence opens a short window, counted in enabled cycles, during which one write to a guarded register may change every bit. The window closes when that write happens or when its cycles run out, whichever comes first. A `winOpen` output shows whether the window is open.

Top module: `tag_top`

## Requirements
- R1: After reset `winOpen` is 0 and every `wrMask` bit is 0 while no write is presented.
- R2: A write of AAh to key address C7h, followed by a write of 55h to C7h as the next bus write, opens the window. `winOpen` goes to 1 in the cycle after the 55h write.
- R3: After an armed AAh, the sequence goes back to locked on a write to any other address or a key write of any value other than 55h or AAh. A key write of AAh arms it again.
- R4: An open window lasts for exactly 3 enabled cycles after the 55h write and then closes unless something has closed it sooner.
- R5: A write to a guarded register that has at least one protected bit closes the window at the end of that cycle. Writes to unguarded addresses do not close it. While the window is open, a key write of AAh re-arms the sequence and any other key write locks it.
- R6: Cycles with `cycEn` low do not advance the window count and do not change the lock state. A write strobe in such a cycle has no effect and produces an all-zero mask.
- R7: Bits [8i+7:8i] of `wrMask` belong to guarded register i. When a guarded register is written and the window is closed, its mask slice enables only the unprotected bits. The slice is zero in every cycle that does not write that register.
- R8: When a guarded register is written while the window is open, all 8 bits of its mask slice are 1.
- R9: The default map guards D8h (protected bits 6, 3, 1, 0), C6h (bits 7 to 5 and 3 to 0), 9Dh (bits 2 to 0) and 91h (no protected bits). A locked write to each of these gives masks B4h, 10h, F8h and FFh in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycEn | input | 1 | Marks a valid bus cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write address |
| wrData | input | 8 | Register write data |
| wrMask | output | 32 | Per-register byte write enables, register i in bits [8i+7:8i] |
| winOpen | output | 1 | The protected-write window is open |

## Verification
A wrong lock state shows at the ports in the very next cycle that writes a guarded register. Its mask slice either includes protected bits it should exclude or leaves out bits it should include, and `winOpen` disagrees with the expected state as soon as the state register updates. A window counter that is off by one shows only on the third enabled cycle after the unlock, so the directed cases write on the last open cycle and on the first closed one. They also put disabled cycles inside the window to check that stalls stretch it. Random traffic weighted toward the key values reaches armed-then-broken sequences and re-arms that directed cases do not try.

// File: rtl/tag_pkg.sv
package tag_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic winOpen;
  } tagCtrlT;

  // Bus events decoded by the datapath for the control
  typedef struct packed {
    logic cycle;     // valid bus cycle
    logic wrCycle;   // valid write
    logic keyAny;    // write to key address
    logic keyFirst;  // first key value
    logic keySecond; // second key value
    logic protWr;    // write to a guarded register with protected bits
  } tagEvtT;
endpackage

// File: rtl/tag_datapath.sv
module tag_datapath
  import tag_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hC7,
  parameter logic [DATA_W-1:0] KEY_FIRST = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55,
  parameter logic [NUM_REGS*ADDR_W-1:0] REG_ADDRS = {8'h91, 8'h9D, 8'hC6, 8'hD8},
  parameter logic [NUM_REGS*DATA_W-1:0] PROT_MASKS = {8'h00, 8'h07, 8'hEF, 8'h4B}
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cycEn,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  tagCtrlT                    ctrl,
  output tagEvtT                     evt,
  output logic [NUM_REGS*DATA_W-1:0] wrMask
);
  logic              wrCycle;
  logic [NUM_REGS-1:0] regHit;
  logic [NUM_REGS-1:0] regGuarded;

  assign wrCycle = cycEn & wrEn;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] RegAddr = REG_ADDRS[i*ADDR_W +: ADDR_W];
    localparam logic [DATA_W-1:0] RegProt = PROT_MASKS[i*DATA_W +: DATA_W];

    assign regHit[i]     = wrCycle && (wrAddr == RegAddr);
    assign regGuarded[i] = (RegProt != '0);
    assign wrMask[i*DATA_W +: DATA_W] =
      !regHit[i]   ? '0 :
      ctrl.winOpen ? '1 : ~RegProt;

    // R7: a locked write never enables a protected bit
    a_r7_locked_no_prot: assert property (@(posedge clk) disable iff (!rstN)
      !ctrl.winOpen |-> ((wrMask[i*DATA_W +: DATA_W] & RegProt) == '0));
    // R7: unprotected bits always enabled on a write to this register
    a_r7_unprot_open: assert property (@(posedge clk) disable iff (!rstN)
      (wrCycle && wrAddr == RegAddr) |-> ((wrMask[i*DATA_W +: DATA_W] & ~RegProt) == ~RegProt));
    // R6: no mask in a disabled cycle
    a_r6_stall_no_mask: assert property (@(posedge clk) disable iff (!rstN)
      !cycEn |-> (wrMask[i*DATA_W +: DATA_W] == '0));
  end

  always_comb begin
    evt.cycle     = cycEn;
    evt.wrCycle   = wrCycle;
    evt.keyAny    = wrCycle && (wrAddr == KEY_ADDR);
    evt.keyFirst  = evt.keyAny && (wrData == KEY_FIRST);
    evt.keySecond = evt.keyAny && (wrData == KEY_SECOND);
    evt.protWr    = |(regHit & regGuarded);
  end
endmodule

// File: rtl/tag_ctrl.sv
module tag_ctrl
  import tag_pkg::*;
#(
  parameter int WIN_CYCLES = 3,
  localparam int CNT_W = $clog2(WIN_CYCLES + 1)
) (
  input  logic    clk,
  input  logic    rstN,
  input  tagEvtT  evt,
  output tagCtrlT ctrl
);
  typedef enum logic [1:0] {ST_LOCKED, ST_ARMED, ST_OPEN} tagStateT;

  tagStateT   state, nxtState;
  logic [CNT_W-1:0] cnt, nxtCnt;

  always_comb begin
    nxtState = state;
    nxtCnt   = cnt;
    unique case (state)
      ST_LOCKED: if (evt.keyFirst) nxtState = ST_ARMED;
      ST_ARMED: begin
        if (evt.wrCycle) begin
          if (evt.keySecond) begin
            nxtState = ST_OPEN;
            nxtCnt   = CNT_W'(WIN_CYCLES);
          end else if (evt.keyFirst) begin
            nxtState = ST_ARMED;
          end else begin
            nxtState = ST_LOCKED;
          end
        end
      end
      ST_OPEN: begin
        if (evt.keyFirst)                   nxtState = ST_ARMED;
        else if (evt.keyAny || evt.protWr)  nxtState = ST_LOCKED;
        else if (cnt == CNT_W'(1))          nxtState = ST_LOCKED;
        else                                nxtCnt   = cnt - CNT_W'(1);
      end
      default: nxtState = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_LOCKED;
      cnt   <= '0;
    end else if (evt.cycle) begin
      state <= nxtState;
      cnt   <= nxtCnt;
    end
  end

  assign ctrl.winOpen = (state == ST_OPEN);

  // R2: the window only opens right after the second key write
  a_r2_open_needs_key: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrl.winOpen) |-> $past(evt.keySecond && evt.cycle));
  // R5: a protected write in the window closes it
  a_r5_close_on_prot: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.winOpen && evt.protWr && evt.cycle) |=> !ctrl.winOpen);
  // R6: stalled cycles leave the state alone
  a_r6_stall_stable: assert property (@(posedge clk) disable iff (!rstN)
    !evt.cycle |=> $stable(ctrl.winOpen));
  // R4: last counted cycle ends the window
  a_r4_expire: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.winOpen && cnt == CNT_W'(1) && evt.cycle && !evt.keyFirst) |=> !ctrl.winOpen);
endmodule

// File: rtl/tag_top.sv
module tag_top
  import tag_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int WIN_CYCLES = 3,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hC7,
  parameter logic [DATA_W-1:0] KEY_FIRST = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55,
  parameter logic [NUM_REGS*ADDR_W-1:0] REG_ADDRS = {8'h91, 8'h9D, 8'hC6, 8'hD8},
  parameter logic [NUM_REGS*DATA_W-1:0] PROT_MASKS = {8'h00, 8'h07, 8'hEF, 8'h4B}
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cycEn,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [NUM_REGS*DATA_W-1:0] wrMask,
  output logic                       winOpen
);
  tagCtrlT ctrl;
  tagEvtT  evt;

  tag_ctrl #(.WIN_CYCLES(WIN_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .ctrl(ctrl)
  );

  tag_datapath #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_ADDR(KEY_ADDR), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND),
    .REG_ADDRS(REG_ADDRS), .PROT_MASKS(PROT_MASKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cycEn(cycEn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .ctrl(ctrl), .evt(evt), .wrMask(wrMask)
  );

  assign winOpen = ctrl.winOpen;
endmodule

// File: tb/tb_tag_top.sv
module tb_tag_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = 8'h00;
  logic [7:0]  wrData = 8'h00;
  logic [31:0] wrMask;
  logic        winOpen;

  int checks = 0;
  int fails = 0;
  int mState = 0;   // 0 locked, 1 armed, 2 open
  int mCnt = 0;
  bit done = 0;

  tag_top dut (.clk(clk), .rstN(rstN), .cycEn(cycEn), .wrEn(wrEn),
               .wrAddr(wrAddr), .wrData(wrData), .wrMask(wrMask), .winOpen(winOpen));

  always #4 clk = ~clk;

  function automatic logic [7:0] regAddr(int i);
    case (i) 0: return 8'hD8; 1: return 8'hC6; 2: return 8'h9D; default: return 8'h91; endcase
  endfunction
  function automatic logic [7:0] regProt(int i);
    case (i) 0: return 8'h4B; 1: return 8'hEF; 2: return 8'h07; default: return 8'h00; endcase
  endfunction

  function automatic logic [31:0] expMask(bit c, bit w, logic [7:0] a, int st);
    logic [31:0] m = '0;
    for (int i = 0; i < 4; i++)
      if (c && w && a == regAddr(i))
        m[i*8 +: 8] = (st == 2) ? 8'hFF : ~regProt(i);
    return m;
  endfunction

  function automatic bit isProtReg(logic [7:0] a);
    for (int i = 0; i < 4; i++)
      if (a == regAddr(i) && regProt(i) != 8'h00) return 1;
    return 0;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle, check outputs mid-cycle, then advance the model.
  task automatic step(bit c, bit w, logic [7:0] a, logic [7:0] d, string tag);
    logic [31:0] em;
    @(negedge clk);
    cycEn = c; wrEn = w; wrAddr = a; wrData = d;
    #1;
    em = expMask(c, w, a, mState);
    check(wrMask == em, tag, "wrMask", wrMask, em);
    check(winOpen == (mState == 2), tag, "winOpen", 32'(winOpen), 32'(mState == 2));
    if (c) begin
      bit wc = w;
      bit key = wc && a == 8'hC7;
      case (mState)
        0: if (key && d == 8'hAA) mState = 1;
        1: if (wc) begin
             if (key && d == 8'h55) begin mState = 2; mCnt = 3; end
             else if (key && d == 8'hAA) mState = 1;
             else mState = 0;
           end
        default: begin
          if (key && d == 8'hAA) mState = 1;
          else if (key || (wc && isProtReg(a))) mState = 0;
          else if (mCnt == 1) mState = 0;
          else mCnt--;
        end
      endcase
    end
  endtask

  task automatic unlock(string tag);
    step(1, 1, 8'hC7, 8'hAA, tag);
    step(1, 1, 8'hC7, 8'h55, tag);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(winOpen == 1'b0, "R1", "winOpen in reset", 32'(winOpen), 0);
    check(wrMask == '0, "R1", "wrMask in reset", wrMask, 0);
    @(negedge clk); rstN = 1'b1;
    step(1, 0, 8'h00, 8'h00, "R1");

    // R9: default map, locked masks
    step(1, 1, 8'hD8, 8'hFF, "R9");
    step(1, 1, 8'hC6, 8'hFF, "R9");
    step(1, 1, 8'h9D, 8'hFF, "R9");
    step(1, 1, 8'h91, 8'hFF, "R9");
    // R7: idle cycle and unguarded address give no mask
    step(1, 0, 8'hD8, 8'h00, "R7");
    step(1, 1, 8'h80, 8'h12, "R7");

    // R2, R8, R5: unlock, write protected register, window closes
    unlock("R2");
    step(1, 1, 8'hD8, 8'h4B, "R8");
    step(1, 1, 8'hD8, 8'h4B, "R5");
    // R5: unguarded and unprotected writes keep it open
    unlock("R5");
    step(1, 1, 8'h80, 8'h00, "R5");
    step(1, 1, 8'h91, 8'h00, "R5");
    step(1, 1, 8'hC6, 8'h00, "R8");
    step(1, 1, 8'hC6, 8'h00, "R5");

    // R4: window lasts three enabled cycles
    unlock("R4");
    step(1, 0, 8'h00, 8'h00, "R4");
    step(1, 0, 8'h00, 8'h00, "R4");
    step(1, 1, 8'h9D, 8'h07, "R4");
    step(1, 1, 8'h9D, 8'h07, "R4");

    // R6: stalls stretch the window and ignore writes
    unlock("R6");
    step(0, 1, 8'hD8, 8'hFF, "R6");
    step(0, 1, 8'hC7, 8'h00, "R6");
    step(1, 0, 8'h00, 8'h00, "R6");
    step(0, 0, 8'h00, 8'h00, "R6");
    step(1, 0, 8'h00, 8'h00, "R6");
    step(0, 0, 8'h00, 8'h00, "R6");
    step(1, 1, 8'hD8, 8'h00, "R6");
    step(1, 1, 8'hD8, 8'h00, "R6");
    // R6: stall between key writes keeps the sequence armed
    step(1, 1, 8'hC7, 8'hAA, "R6");
    step(0, 1, 8'hD8, 8'h00, "R6");
    step(1, 1, 8'hC7, 8'h55, "R6");
    step(1, 1, 8'hC6, 8'h00, "R6");

    // R3: broken sequences
    step(1, 1, 8'hC7, 8'hAA, "R3");
    step(1, 1, 8'h80, 8'h00, "R3");
    step(1, 1, 8'hC7, 8'h55, "R3");
    step(1, 1, 8'hD8, 8'h00, "R3");
    step(1, 1, 8'hC7, 8'hAA, "R3");
    step(1, 1, 8'hC7, 8'h12, "R3");
    step(1, 1, 8'hC7, 8'h55, "R3");
    step(1, 1, 8'hD8, 8'h00, "R3");
    step(1, 1, 8'hC7, 8'hAA, "R3");
    step(1, 1, 8'hC7, 8'hAA, "R3");
    step(1, 1, 8'hC7, 8'h55, "R3");
    step(1, 1, 8'hD8, 8'h00, "R3");
    // R5: key writes while open
    unlock("R5");
    step(1, 1, 8'hC7, 8'h00, "R5");
    step(1, 1, 8'hD8, 8'h00, "R5");
    unlock("R5");
    step(1, 1, 8'hC7, 8'hAA, "R5");
    step(1, 1, 8'hC7, 8'h55, "R5");
    step(1, 1, 8'hD8, 8'h00, "R5");

    // R7/R8 random traffic
    for (int n = 0; n < 4000; n++) begin
      int ai = $urandom % 8;
      int di = $urandom % 4;
      logic [7:0] a = (ai < 3) ? 8'hC7 : (ai == 7) ? 8'h80 : regAddr(ai - 3);
      logic [7:0] d = (di == 0) ? 8'hAA : (di == 1) ? 8'h55 : 8'($urandom);
      step(($urandom % 5) != 0, ($urandom % 10) < 7, a, d, "R7/R8");
    end

    done = 1;
    finishRun();
  end
endmodule